// File: doc/BRIEF.md
# Ultra DMA Device Burst Engine

This block runs the device side of Ultra DMA bursts on a 16-bit parallel disk interface. The block samples every host signal with a fast system clock. Local logic starts a burst with a direction flag and a word count. The engine then raises its DMA request and waits until the host acknowledges. After that it runs one of two burst types. In a data-in burst it pops words from a local transmit FIFO, drives them onto the bus and marks each word by toggling its own strobe. The host's ready line paces this flow. In a data-out burst it captures one bus word on every change of the host strobe and pushes each word into a local receive FIFO.

Both directions pass every transferred word through a CRC-16. When the word count runs out, the engine drops its request and waits for the host to release the acknowledge. It then compares its CRC with the value the host supplied and reports the result with a one-cycle completion pulse. The host control inputs and the data bus pass through a two-flop synchronizer before any logic uses them.

Top module: `udma_burst_dev`

## Requirements
- R1: While reset is active and right after it, `dev_req`, `bus_oe`, `dev_stb`, `tx_pop`, `rx_push`, `done` and `crc_err` are all 0.
- R2: In idle, a `start` pulse with a nonzero `word_count` raises `dev_req`. A `start` with `word_count` equal to 0 is ignored. A `start` while a burst is running has no effect on that burst.
- R3: No word moves before `host_ack` is seen high. After the acknowledge, `dir_in`=1 gives a data-in burst with `bus_oe`=1. `dir_in`=0 gives a data-out burst with `bus_oe`=0.
- R4: In a data-in burst, each word popped from the transmit FIFO appears on `bus_out` in FIFO order. `dev_stb` toggles exactly once per word and never at any other time.
- R5: Data-in words are sent only while `host_rdy` is high. After `host_rdy` falls, at most 3 more strobe toggles occur. `dev_stb` then holds until `host_rdy` returns.
- R6: In a data-out burst, a rising or a falling change of `host_stb` each captures one `bus_in` word. The words are pushed on `rx_data` in arrival order.
- R7: While `host_stb` is static, no words are captured in a data-out burst.
- R8: An empty transmit FIFO stalls a data-in burst with no strobe toggles, and `dev_req` stays high. While `rx_full` is high, `dev_rdy` is 0. A strobe edge that arrives then is dropped and is not counted.
- R9: After `word_count` words, `dev_req` falls while `host_ack` is still high. `done` pulses for exactly one cycle only after `host_ack` is seen low, and the engine returns to idle.
- R10: The CRC uses polynomial 0x1021, seed 0x4ABA, and takes each 16-bit word most significant bit first. It covers every transferred word. At `done`, `crc_err` is set if the result differs from `host_crc`. `crc_err` holds until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst (accepted in idle only) |
| dir_in | input | 1 | 1 = data-in (device to host), 0 = data-out |
| word_count | input | 16 | Number of words in the burst |
| dev_req | output | 1 | DMA request to host |
| host_ack | input | 1 | DMA acknowledge from host (asynchronous) |
| host_rdy | input | 1 | Host ready for data-in words (asynchronous) |
| host_stb | input | 1 | Host data-out strobe, both edges active (asynchronous) |
| dev_rdy | output | 1 | Device can accept data-out words |
| dev_stb | output | 1 | Device data-in strobe, toggles once per word |
| bus_in | input | 16 | Data bus from host |
| bus_out | output | 16 | Data bus to host |
| bus_oe | output | 1 | Bus output enable (data-in burst) |
| tx_data | input | 16 | Head word of transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Pop transmit FIFO |
| rx_data | output | 16 | Word to receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push receive FIFO |
| host_crc | input | 16 | CRC supplied by the host, compared at burst end |
| done | output | 1 | One-cycle pulse at burst completion |
| crc_err | output | 1 | CRC mismatch on the last burst |

## Verification
The bench drops `host_rdy` in the middle of a long data-in burst. It counts the strobe toggles that follow and then watches for silence. An engine that ignored the ready line, or that overran without limit, would keep toggling. It alternates rising and falling host strobes and also holds the strobe still. A capture on one edge only would halve the word count, and a level-based capture would repeat words. It starves the transmit FIFO, fills the receive FIFO, issues a zero-count start and issues a start during a burst. Each case targets a stall that loses its request, a dropped word that is still counted, or a burst that gets hijacked. It also holds the acknowledge after the last word, which exposes an early `done`, and it supplies a wrong CRC, which exposes a missing mismatch flag.

// File: rtl/udma_pkg.sv
package udma_pkg;
    localparam int UDMA_DW    = 16;
    localparam int UDMA_CW    = 16;
    localparam int UDMA_CRCW  = 16;
    localparam logic [UDMA_CRCW-1:0] UDMA_POLY = 16'h1021;
    localparam logic [UDMA_CRCW-1:0] UDMA_SEED = 16'h4ABA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_IN,
        ST_OUT,
        ST_DRAIN
    } burst_st_e;
endpackage

// File: rtl/udma_sync2.sv
module udma_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/udma_toggle_det.sv
module udma_toggle_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // any change of the synchronized level, rising or falling
    assign pulse = lvl ^ prev_q;
endmodule

// File: rtl/udma_crc_step.sv
module udma_crc_step #(
    parameter int                DW    = 16,
    parameter int                CRC_W = 16,
    parameter logic [CRC_W-1:0]  POLY  = 16'h1021
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [DW-1:0]    word,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int i = DW - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ word[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/udma_burst_dev.sv
module udma_burst_dev
    import udma_pkg::*;
#(
    parameter int                    DW    = UDMA_DW,
    parameter int                    CW    = UDMA_CW,
    parameter logic [UDMA_CRCW-1:0]  POLY  = UDMA_POLY,
    parameter logic [UDMA_CRCW-1:0]  SEED  = UDMA_SEED
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 dir_in,
    input  logic [CW-1:0]        word_count,
    output logic                 dev_req,
    input  logic                 host_ack,
    input  logic                 host_rdy,
    input  logic                 host_stb,
    output logic                 dev_rdy,
    output logic                 dev_stb,
    input  logic [DW-1:0]        bus_in,
    output logic [DW-1:0]        bus_out,
    output logic                 bus_oe,
    input  logic [DW-1:0]        tx_data,
    input  logic                 tx_empty,
    output logic                 tx_pop,
    output logic [DW-1:0]        rx_data,
    input  logic                 rx_full,
    output logic                 rx_push,
    input  logic [UDMA_CRCW-1:0] host_crc,
    output logic                 done,
    output logic                 crc_err
);
    localparam int CRCW = UDMA_CRCW;
    localparam int SW   = DW + 3;

    typedef struct packed {
        burst_st_e       st;
        logic            dir_in;
        logic [CW-1:0]   cnt;
        logic [CRCW-1:0] crc;
        logic [DW-1:0]   bus_out;
        logic            dev_stb;
        logic            done;
        logic            crc_err;
    } burst_regs_t;

    burst_regs_t r_d, r_q;

    // synchronized host side
    logic [SW-1:0] raw_host, syn_host;
    logic          ack_s, rdy_s, stb_s;
    logic [DW-1:0] bus_s;
    logic          stb_edge;

    assign raw_host = {host_ack, host_rdy, host_stb, bus_in};

    udma_sync2 #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_host),
        .q     (syn_host)
    );

    assign {ack_s, rdy_s, stb_s, bus_s} = syn_host;

    udma_toggle_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (stb_s),
        .pulse (stb_edge)
    );

    // one CRC step shared by both directions
    logic [DW-1:0]   crc_word;
    logic [CRCW-1:0] crc_next;

    assign crc_word = (r_q.st == ST_IN) ? tx_data : bus_s;

    udma_crc_step #(.DW(DW), .CRC_W(CRCW), .POLY(POLY)) u_crc (
        .crc_in  (r_q.crc),
        .word    (crc_word),
        .crc_out (crc_next)
    );

    logic send_ok, take_ok;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        send_ok  = 1'b0;
        take_ok  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start && (word_count != '0)) begin
                    r_d.st      = ST_REQ;
                    r_d.dir_in  = dir_in;
                    r_d.cnt     = word_count;
                    r_d.crc     = SEED;
                    r_d.crc_err = 1'b0;
                end
            end
            ST_REQ: begin
                if (ack_s) r_d.st = r_q.dir_in ? ST_IN : ST_OUT;
            end
            ST_IN: begin
                send_ok = rdy_s && !tx_empty;
                if (send_ok) begin
                    r_d.bus_out = tx_data;
                    r_d.dev_stb = ~r_q.dev_stb;
                    r_d.crc     = crc_next;
                    r_d.cnt     = r_q.cnt - 1'b1;
                    if (r_q.cnt == CW'(1)) r_d.st = ST_DRAIN;
                end
            end
            ST_OUT: begin
                take_ok = stb_edge && !rx_full;
                if (take_ok) begin
                    r_d.crc = crc_next;
                    r_d.cnt = r_q.cnt - 1'b1;
                    if (r_q.cnt == CW'(1)) r_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!ack_s) begin
                    r_d.st      = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.crc_err = (r_q.crc != host_crc);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, dir_in: 1'b0, cnt: '0, crc: SEED,
                     bus_out: '0, dev_stb: 1'b0, done: 1'b0, crc_err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dev_req = (r_q.st == ST_REQ) || (r_q.st == ST_IN) || (r_q.st == ST_OUT);
    assign bus_oe  = (r_q.st == ST_IN);
    assign dev_rdy = (r_q.st == ST_OUT) && !rx_full;
    assign dev_stb = r_q.dev_stb;
    assign bus_out = r_q.bus_out;
    assign tx_pop  = send_ok;
    assign rx_push = take_ok;
    assign rx_data = bus_s;
    assign done    = r_q.done;
    assign crc_err = r_q.crc_err;
endmodule

// File: rtl/udma_burst_chk.sv
module udma_burst_chk (
    input logic clk,
    input logic rst_n,
    input logic host_rdy,
    input logic dev_stb,
    input logic tx_pop,
    input logic tx_empty,
    input logic rx_push,
    input logic rx_full,
    input logic bus_oe,
    input logic dev_req,
    input logic done
);
    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R8

    AST_PUSH_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R8

    AST_STB_ONLY_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_stb) |-> $past(tx_pop)); // R4

    AST_PAUSE_HOLDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rdy && !$past(host_rdy) && !$past(host_rdy, 2) && !$past(host_rdy, 3))
        |-> $stable(dev_stb)); // R5

    AST_PUSH_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !bus_oe); // R3

    AST_XFER_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop || rx_push) |-> dev_req); // R3

    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dev_req && !$past(dev_req))); // R9
endmodule

bind udma_burst_dev udma_burst_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_rdy (host_rdy),
    .dev_stb  (dev_stb),
    .tx_pop   (tx_pop),
    .tx_empty (tx_empty),
    .rx_push  (rx_push),
    .rx_full  (rx_full),
    .bus_oe   (bus_oe),
    .dev_req  (dev_req),
    .done     (done)
);

// File: tb/tb_udma_burst_dev.sv
module tb_udma_burst_dev;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_in = 1'b0;
    logic [15:0] word_count = '0;
    logic        dev_req, dev_rdy, dev_stb, bus_oe, tx_pop, rx_push, done, crc_err;
    logic        host_ack = 1'b0, host_rdy = 1'b1, host_stb = 1'b0;
    logic [15:0] bus_in = '0, bus_out, tx_data, rx_data;
    logic        tx_empty, rx_full = 1'b0;
    logic [15:0] host_crc = '0;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    logic [15:0] tx_mem [64];
    int tx_idx = 0, tx_lim = 0;
    logic [15:0] rx_mem [64];
    int rx_cnt = 0;
    logic [15:0] in_mem [64];
    int in_cnt = 0;
    logic stb_seen = 1'b0;

    always #10 clk = ~clk;

    udma_burst_dev dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in),
        .word_count(word_count), .dev_req(dev_req), .host_ack(host_ack),
        .host_rdy(host_rdy), .host_stb(host_stb), .dev_rdy(dev_rdy),
        .dev_stb(dev_stb), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_full(rx_full), .rx_push(rx_push),
        .host_crc(host_crc), .done(done), .crc_err(crc_err)
    );

    // local FIFO models and host-side strobe observer
    assign tx_data  = tx_mem[tx_idx % 64];
    assign tx_empty = (tx_idx >= tx_lim);

    always @(posedge clk) begin
        if (tx_pop) tx_idx <= tx_idx + 1;
        if (rx_push) begin
            rx_mem[rx_cnt % 64] <= rx_data;
            rx_cnt <= rx_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (dev_stb !== stb_seen) begin
            in_mem[in_cnt % 64] = bus_out;
            in_cnt   = in_cnt + 1;
            stb_seen = dev_stb;
        end
    end

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] ^ w[b]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic kick(input logic d, input logic [15:0] n);
        @(negedge clk);
        start = 1'b1; dir_in = d; word_count = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_req(input logic lvl);
        for (int i = 0; i < 600 && dev_req !== lvl; i++) @(negedge clk);
    endtask

    task automatic finish_burst(input logic [15:0] hc, input logic exp_err);
        bit seen = 1'b0;
        host_crc = hc;
        wait_req(1'b0);
        chk("R9", "req drops at count end", dev_req, 1'b0);
        repeat (5) @(negedge clk);
        chk("R9", "no done while ack held", done, 1'b0);
        host_ack = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
        chk("R9", "done after ack release", seen, 1'b1);
        chk("R10", "crc_err at done", crc_err, exp_err);
        @(negedge clk);
        chk("R9", "done one cycle", done, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1", "dev_req", dev_req, 1'b0);
        chk("R1", "bus_oe", bus_oe, 1'b0);
        chk("R1", "dev_stb", dev_stb, 1'b0);
        chk("R1", "pops/pushes", {tx_pop, rx_push}, 2'b00);
        chk("R1", "done/crc_err", {done, crc_err}, 2'b00);
    endtask

    task automatic t_zero_count;
        kick(1'b1, 16'd0);
        repeat (5) @(negedge clk);
        chk("R2", "zero count ignored", dev_req, 1'b0);
    endtask

    task automatic t_in_basic;
        logic [15:0] c = 16'h4ABA;
        int ib = in_cnt;
        for (int i = 0; i < 8; i++) begin
            tx_mem[(tx_idx + i) % 64] = 16'h1000 + 16'(i * 16'h0111);
            c = crc_upd(c, 16'h1000 + 16'(i * 16'h0111));
        end
        tx_lim = tx_idx + 8;
        kick(1'b1, 16'd8);
        wait_req(1'b1);
        chk("R2", "request raised", dev_req, 1'b1);
        repeat (6) @(negedge clk);
        chk("R3", "no words before ack", in_cnt - ib, 0);
        chk("R3", "bus idle before ack", bus_oe, 1'b0);
        host_ack = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3", "data-in drives bus", bus_oe, 1'b1);
        finish_burst(c, 1'b0);
        chk("R4", "word count in", in_cnt - ib, 8);
        for (int i = 0; i < 8; i++)
            chk("R4", "word order in", in_mem[(ib + i) % 64], 16'h1000 + 16'(i * 16'h0111));
    endtask

    task automatic t_in_pause;
        logic [15:0] c = 16'h4ABA;
        int ib = in_cnt;
        int c0, c1;
        for (int i = 0; i < 20; i++) begin
            tx_mem[(tx_idx + i) % 64] = 16'hA000 ^ 16'(i * 16'h0305);
            c = crc_upd(c, 16'hA000 ^ 16'(i * 16'h0305));
        end
        tx_lim = tx_idx + 20;
        kick(1'b1, 16'd20);
        wait_req(1'b1);
        host_ack = 1'b1;
        for (int i = 0; i < 100 && (in_cnt - ib) < 5; i++) @(negedge clk);
        host_rdy = 1'b0;
        c0 = in_cnt;
        repeat (5) @(negedge clk);
        c1 = in_cnt;
        chk("R5", "overrun at most 3", (c1 - c0) <= 3, 1'b1);
        repeat (10) @(negedge clk);
        chk("R5", "strobe holds while paused", in_cnt, c1);
        host_rdy = 1'b1;
        finish_burst(c, 1'b0);
        chk("R5", "all words after resume", in_cnt - ib, 20);
        for (int i = 0; i < 20; i++)
            chk("R4", "order across pause", in_mem[(ib + i) % 64], 16'hA000 ^ 16'(i * 16'h0305));
    endtask

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        bus_in = w;
        @(negedge clk);
        host_stb = ~host_stb;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_out;
        logic [15:0] c = 16'h4ABA;
        int rb = rx_cnt;
        kick(1'b0, 16'd6);
        wait_req(1'b1);
        host_ack = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3", "data-out leaves bus", bus_oe, 1'b0);
        chk("R8", "ready when room", dev_rdy, 1'b1);
        for (int i = 0; i < 3; i++) begin
            send_word(16'h5A00 + 16'(i));
            c = crc_upd(c, 16'h5A00 + 16'(i));
        end
        chk("R6", "captures on both edges", rx_cnt - rb, 3);
        repeat (10) @(negedge clk);
        chk("R7", "static strobe no capture", rx_cnt - rb, 3);
        rx_full = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "not ready when full", dev_rdy, 1'b0);
        send_word(16'hDEAD);
        chk("R8", "edge while full dropped", rx_cnt - rb, 3);
        chk("R8", "request held while full", dev_req, 1'b1);
        rx_full = 1'b0;
        for (int i = 3; i < 6; i++) begin
            send_word(16'h5A00 + 16'(i));
            c = crc_upd(c, 16'h5A00 + 16'(i));
        end
        finish_burst(c ^ 16'h0001, 1'b1);
        chk("R6", "word count out", rx_cnt - rb, 6);
        for (int i = 0; i < 6; i++)
            chk("R6", "word order out", rx_mem[(rb + i) % 64], 16'h5A00 + 16'(i));
    endtask

    task automatic t_tx_stall;
        logic [15:0] c = 16'h4ABA;
        int ib = in_cnt;
        for (int i = 0; i < 6; i++) begin
            tx_mem[(tx_idx + i) % 64] = 16'h3C00 | 16'(i);
            c = crc_upd(c, 16'h3C00 | 16'(i));
        end
        tx_lim = tx_idx + 3;
        kick(1'b1, 16'd6);
        chk("R10", "start clears crc_err", crc_err, 1'b0);
        wait_req(1'b1);
        host_ack = 1'b1;
        repeat (14) @(negedge clk);
        chk("R8", "stall on empty", in_cnt - ib, 3);
        chk("R8", "request kept while empty", dev_req, 1'b1);
        kick(1'b0, 16'd1);
        repeat (3) @(negedge clk);
        chk("R2", "start while busy ignored", bus_oe, 1'b1);
        tx_lim = tx_lim + 3;
        finish_burst(c, 1'b0);
        chk("R8", "resume after refill", in_cnt - ib, 6);
        for (int i = 0; i < 6; i++)
            chk("R4", "order across stall", in_mem[(ib + i) % 64], 16'h3C00 | 16'(i));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_zero_count();
        t_in_basic();
        t_in_pause();
        t_out();
        t_tx_stall();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule